// File: doc/BRIEF.md
# Back-Porch Clamp Pulse Generator

This block produces two digital timing pulses for each video line from a single system clock: a clamp pulse that gates the input black-level clamp during the back porch, and a sample pulse that tells the output sample-and-hold when to take the blanking level. The clamp pulse is started by an edge on either the horizontal sync pin or the blanking pin. The sync polarity is found automatically, the blanking polarity comes from a configuration bit, and the pulse length is one of four fixed durations, rounded to whole clock cycles of the configured clock. An external clamp pulse on the sync pin can replace the internally timed one. The sample pulse is timed from the blanking leading edge or copies the clamp pulse. Two test bits force either pulse high.

Both pins pass through a two-flop synchronizer. A pulse timer is a two-state machine: `TMR_IDLE` waits. A trigger moves it to `TMR_RUN` and loads the width counter. In `TMR_RUN` a new trigger reloads the counter, and expiry of the counter returns it to `TMR_IDLE`. The sync polarity detector has two states. `POL_SEEK` waits for the first rising sync edge and then enters `POL_MEASURE`. `POL_MEASURE` counts high and low cycles, and on each later rising edge it makes a polarity decision and restarts the count. Both detector transitions are taken on a rising sync edge.

The 8-bit control word `ctrl_i` holds: bit 0 source (0 sync, 1 blanking), bit 1 sync edge (0 trailing, 1 leading), bits 3:2 width code, bit 4 external bypass, bit 5 force clamp pulse, bit 6 force sample pulse, bit 7 sample-pulse source. The host register that drives it resets to 0x04.

Top module: `clamp_pulse_gen`

## Requirements
- R1: The width code selects 333, 667, 1000 or 1333 ns, for codes 0 to 3. The timed clamp pulse stays high for W = round(ns * CLK_HZ / 1e9) clock cycles, with a minimum of 1. The code is taken when the pulse is triggered.
- R2: A timed pulse goes high after the third rising clock edge that follows the trigger edge reaching the pin, and a bench sampling between edges sees it in the third sample.
- R3: With ctrl_i[0]=0 the clamp pulse is triggered by the sync edge that ctrl_i[1] selects (0 trailing, 1 leading). With ctrl_i[0]=1 it is triggered by the blanking leading edge. Each line gives exactly one pulse.
- R4: Sync polarity is detected without configuration. Over each full rise-to-rise period, the level held for fewer cycles is taken as active, and a tie counts as positive. Positive polarity is used until the first full period has been measured.
- R5: blk_neg_i=0 makes the blanking pin active-high, and blk_neg_i=1 makes it active-low.
- R6: With ctrl_i[4]=1 the clamp pulse equals the synchronized sync pin: it is delayed by two clock edges, seen in the second sample, and its length equals the pin pulse. Bits 3:0 then have no effect.
- R7: ctrl_i[5]=1 holds bpcp_o high and ctrl_i[6]=1 holds ocl_o high. Both take effect combinationally.
- R8: With ctrl_i[7]=0, ocl_o is timed from the blanking leading edge with the same width W. With ctrl_i[7]=1, ocl_o equals bpcp_o.
- R9: A trigger that arrives while a pulse is high restarts the count, so the pulse ends W cycles after the last trigger is taken.
- R10: While reset is applied, and with the force bits clear, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_pin_i | input | 1 | Horizontal sync, or external clamp pulse, pin |
| blk_pin_i | input | 1 | Blanking pin |
| blk_neg_i | input | 1 | Blanking polarity, 1 = active-low |
| ctrl_i | input | 8 | Pulse control word |
| bpcp_o | output | 1 | Clamp pulse |
| ocl_o | output | 1 | Output sample pulse |

## Verification
The hardest case to reach is a negative sync after the polarity detector has settled. The edge that fires the pulse then changes direction on the pin, and a wrong polarity decision only shows up as a pulse that starts one sync-pulse length early or late. To reach it, the bench drives each configuration for several warm-up lines that alternate a short active level with a long idle level, and only then measures the pulse start against the leading or trailing edge it drove. The sweep covers every width code, both edges, both sync polarities and both blanking polarities. The retrigger case is reached with two blanking assertions closer together than the pulse width.

// File: rtl/cpg_pkg.sv
package cpg_pkg;

    localparam int unsigned CB_SRC  = 0;
    localparam int unsigned CB_EDGE = 1;
    localparam int unsigned CB_WLO  = 2;
    localparam int unsigned CB_WHI  = 3;
    localparam int unsigned CB_BYP  = 4;
    localparam int unsigned CB_FBP  = 5;
    localparam int unsigned CB_FOC  = 6;
    localparam int unsigned CB_OSRC = 7;

    localparam logic [7:0] CTRL_RESET = 8'h04;

    typedef enum logic {
        TMR_IDLE,
        TMR_RUN
    } tmr_state_e;

    typedef enum logic {
        POL_SEEK,
        POL_MEASURE
    } pol_state_e;

    function automatic longint unsigned width_ns(input logic [1:0] code);
        longint unsigned ns;
        unique case (code)
            2'd0: ns = 64'd333;
            2'd1: ns = 64'd667;
            2'd2: ns = 64'd1000;
            default: ns = 64'd1333;
        endcase
        return ns;
    endfunction

    function automatic int unsigned width_cycles(input longint unsigned hz,
                                                 input logic [1:0] code);
        longint unsigned c;
        c = (width_ns(code) * hz + 64'd500_000_000) / 64'd1_000_000_000;
        if (c == 0) c = 1;
        return int'(c);
    endfunction

endpackage

// File: rtl/cpg_edge_sync.sv
module cpg_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= pin_i;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], pin_i};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    always_comb begin
        level_o = chain_q[STAGES-1];
        rise_o  = level_o & ~prev_q;
        fall_o  = ~level_o & prev_q;
    end

    // An edge lasts exactly one cycle (R2)
    assert_rise_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
    assert_fall_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);

endmodule

// File: rtl/cpg_hs_polarity.sv
module cpg_hs_polarity
    import cpg_pkg::*;
#(
    parameter int unsigned MEAS_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    input  logic rise_i,
    output logic neg_o
);
    pol_state_e        state_q, state_n;
    logic [MEAS_W-1:0] hi_q, lo_q;
    logic              neg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= POL_SEEK;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            POL_SEEK:    if (rise_i) state_n = POL_MEASURE;
            POL_MEASURE: state_n = POL_MEASURE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (rise_i) begin
            hi_q <= MEAS_W'(1);
            lo_q <= '0;
        end else if (state_q == POL_MEASURE) begin
            if (level_i) begin
                if (hi_q != '1) hi_q <= hi_q + 1'b1;
            end else begin
                if (lo_q != '1) lo_q <= lo_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               neg_q <= 1'b0;
        else if (rise_i && state_q == POL_MEASURE) neg_q <= (hi_q > lo_q);
    end

    assign neg_o = neg_q;

    // Positive until a full period has been measured (R4)
    assert_seek_positive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == POL_SEEK) |-> !neg_q);
    // Polarity only moves at the end of a measured period (R4)
    assert_pol_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(neg_q) |-> $past(rise_i && state_q == POL_MEASURE));

endmodule

// File: rtl/cpg_pulse_timer.sv
module cpg_pulse_timer
    import cpg_pkg::*;
#(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig_i,
    input  logic [CW-1:0] width_i,
    output logic          active_o
);
    tmr_state_e    state_q, state_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic [CW-1:0] wid_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TMR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      wid_q <= '0;
        else if (trig_i) wid_q <= width_i;
    end

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        unique case (state_q)
            TMR_IDLE: begin
                if (trig_i) begin
                    state_n = TMR_RUN;
                    cnt_n   = width_i - 1'b1;
                end
            end
            TMR_RUN: begin
                if (trig_i)           cnt_n   = width_i - 1'b1;
                else if (cnt_q == '0) state_n = TMR_IDLE;
                else                  cnt_n   = cnt_q - 1'b1;
            end
        endcase
    end

    always_comb active_o = (state_q == TMR_RUN);

    // Counter stays inside the latched width (R1)
    assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TMR_RUN) |-> (cnt_q < wid_q));
    // Expiry ends the pulse (R1)
    assert_expire_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TMR_RUN && !trig_i && cnt_q == '0) |=> (state_q == TMR_IDLE));
    // Any trigger (re)loads the full width (R9)
    assert_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trig_i |=> (state_q == TMR_RUN && cnt_q == $past(width_i) - 1'b1));

endmodule

// File: rtl/clamp_pulse_gen.sv
module clamp_pulse_gen
    import cpg_pkg::*;
#(
    parameter longint unsigned CLK_HZ = 150_000_000,
    parameter int unsigned     MEAS_W = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hs_pin_i,
    input  logic       blk_pin_i,
    input  logic       blk_neg_i,
    input  logic [7:0] ctrl_i,
    output logic       bpcp_o,
    output logic       ocl_o
);
    localparam int unsigned W0 = width_cycles(CLK_HZ, 2'd0);
    localparam int unsigned W1 = width_cycles(CLK_HZ, 2'd1);
    localparam int unsigned W2 = width_cycles(CLK_HZ, 2'd2);
    localparam int unsigned W3 = width_cycles(CLK_HZ, 2'd3);
    localparam int unsigned CW = $clog2(W3 + 1);
    localparam int unsigned NT = 2;

    logic hs_lvl, hs_rise, hs_fall;
    logic blk_lvl, blk_rise, blk_fall;
    logic hs_neg;
    logic hs_lead, hs_trail, blk_lead;
    logic bpcp_trig;
    logic [CW-1:0] width_sel;
    logic [NT-1:0] trig_v, act_v;
    logic bpcp_int;

    cpg_edge_sync #(.STAGES(2)) u_hs_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(hs_pin_i),
        .level_o(hs_lvl), .rise_o(hs_rise), .fall_o(hs_fall)
    );

    cpg_edge_sync #(.STAGES(2)) u_blk_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(blk_pin_i),
        .level_o(blk_lvl), .rise_o(blk_rise), .fall_o(blk_fall)
    );

    cpg_hs_polarity #(.MEAS_W(MEAS_W)) u_pol (
        .clk(clk), .rst_n(rst_n), .level_i(hs_lvl), .rise_i(hs_rise),
        .neg_o(hs_neg)
    );

    always_comb begin
        hs_lead   = hs_neg ? hs_fall : hs_rise;
        hs_trail  = hs_neg ? hs_rise : hs_fall;
        blk_lead  = blk_neg_i ? blk_fall : blk_rise;
        if (ctrl_i[CB_SRC]) bpcp_trig = blk_lead;
        else                bpcp_trig = ctrl_i[CB_EDGE] ? hs_lead : hs_trail;
    end

    always_comb begin
        unique case (ctrl_i[CB_WHI:CB_WLO])
            2'd0:    width_sel = CW'(W0);
            2'd1:    width_sel = CW'(W1);
            2'd2:    width_sel = CW'(W2);
            default: width_sel = CW'(W3);
        endcase
    end

    assign trig_v[0] = bpcp_trig;
    assign trig_v[1] = blk_lead;

    generate
        for (genvar t = 0; t < NT; t++) begin : g_tmr
            cpg_pulse_timer #(.CW(CW)) u_tmr (
                .clk(clk), .rst_n(rst_n), .trig_i(trig_v[t]),
                .width_i(width_sel), .active_o(act_v[t])
            );
        end
    endgenerate

    always_comb begin
        bpcp_int = ctrl_i[CB_BYP] ? hs_lvl : act_v[0];
        bpcp_o   = bpcp_int | ctrl_i[CB_FBP];
        ocl_o    = ctrl_i[CB_FOC] | (ctrl_i[CB_OSRC] ? bpcp_o : act_v[1]);
    end

    // Timed sample pulse follows a blanking leading edge (R8)
    assert_ocl_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_lead && !ctrl_i[CB_OSRC]) |=> ocl_o);
    // Bypass tracks the synchronized pin (R6)
    assert_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_i[CB_BYP] && !ctrl_i[CB_FBP] && $rose(hs_lvl)) |-> bpcp_o);

endmodule

// File: tb/clamp_pulse_gen_bench.sv
module clamp_pulse_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam longint BCLK_HZ = 6_000_000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hs_pin = 1'b0, blk_pin = 1'b0, blk_neg = 1'b0;
    logic [7:0] ctrl = 8'h04;
    logic bpcp_o, ocl_o;

    int total = 0, bad = 0, cyc = 0;
    int b_start = 0, b_len = 0, b_n = 0, o_start = 0, o_len = 0, o_n = 0;
    logic b_prev = 1'b0, o_prev = 1'b0;

    clamp_pulse_gen #(.CLK_HZ(BCLK_HZ)) u_clamp_pulse_gen (
        .clk(clk), .rst_n(rst_n), .hs_pin_i(hs_pin), .blk_pin_i(blk_pin),
        .blk_neg_i(blk_neg), .ctrl_i(ctrl), .bpcp_o(bpcp_o), .ocl_o(ocl_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (bpcp_o && !b_prev) b_start = cyc;
        if (!bpcp_o && b_prev) begin b_len = cyc - b_start; b_n = b_n + 1; end
        b_prev = bpcp_o;
        if (ocl_o && !o_prev) o_start = cyc;
        if (!ocl_o && o_prev) begin o_len = cyc - o_start; o_n = o_n + 1; end
        o_prev = ocl_o;
    end

    function automatic int exp_w(input int code);
        longint ns;
        longint c;
        ns = (code == 0) ? 333 : (code == 1) ? 667 : (code == 2) ? 1000 : 1333;
        c = (ns * BCLK_HZ + 500_000_000) / 1_000_000_000;
        if (c < 1) c = 1;
        return int'(c);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total = total + 1;
        if (act != exp) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic hs_line(input int act_len, input int gap, input logic neg,
                           output int lead_c, output int trail_c);
        hs_pin = ~neg; lead_c = cyc;
        step(act_len);
        hs_pin = neg; trail_c = cyc;
        step(gap);
    endtask

    task automatic blk_line(input int act_len, input int gap, input logic neg,
                            output int lead_c);
        blk_pin = ~neg; lead_c = cyc;
        step(act_len);
        blk_pin = neg;
        step(gap);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        total = total + 1; bad = bad + 1;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lc, tc, nb, no, w;
        step(3);
        // R10: outputs low in reset
        check("R10 bpcp in reset", int'(bpcp_o), 0);
        check("R10 ocl in reset", int'(ocl_o), 0);
        rst_n = 1'b1;
        step(3);
        check("R10 bpcp after reset", int'(bpcp_o), 0);

        // R4: positive assumed before any measurement, leading edge, code 1
        ctrl = 8'h06;
        nb = b_n;
        hs_line(10, 40, 1'b0, lc, tc);
        check("R4 default positive count", b_n, nb + 1);
        check("R4 default positive start", b_start, lc + 3);
        check("R1 default width", b_len, exp_w(1));

        // Sweep: sources, edges, polarities, width codes
        for (int m = 0; m < 6; m++) begin
            for (int code = 0; code < 4; code++) begin
                logic hneg, lead, bsrc, bneg;
                hneg = (m == 2 || m == 3);
                lead = (m == 1 || m == 3);
                bsrc = (m >= 4);
                bneg = (m == 5);
                w = exp_w(code);
                ctrl = {~bsrc, 3'b000, code[1:0], lead, bsrc};
                blk_neg = bneg;
                blk_pin = bneg;
                hs_pin = bsrc ? 1'b0 : hneg;
                step(20);
                for (int k = 0; k < 3; k++) begin
                    if (bsrc) blk_line(12, 40, bneg, lc);
                    else      hs_line(10, 40, hneg, lc, tc);
                end
                for (int k = 0; k < 2; k++) begin
                    nb = b_n; no = o_n;
                    if (bsrc) begin
                        blk_line(12, 40, bneg, lc);
                        check("R3 blk pulse count", b_n, nb + 1);
                        check("R5 blk pulse start", b_start, lc + 3);
                        check("R1 blk pulse width", b_len, w);
                        check("R8 ocl timed start", o_start, lc + 3);
                        check("R8 ocl timed width", o_len, w);
                    end else begin
                        hs_line(10, 40, hneg, lc, tc);
                        check("R3 hs pulse count", b_n, nb + 1);
                        check("R4 R2 hs pulse start", b_start, (lead ? lc : tc) + 3);
                        check("R1 hs pulse width", b_len, w);
                        check("R8 ocl copy start", o_start, b_start);
                        check("R8 ocl copy count", o_n, no + 1);
                    end
                end
            end
        end

        // R9: retrigger inside an active pulse
        ctrl = 8'h0D; blk_neg = 1'b0; blk_pin = 1'b0; hs_pin = 1'b0;
        step(20);
        lc = cyc;
        blk_pin = 1'b1; step(2); blk_pin = 1'b0; step(2);
        blk_pin = 1'b1; step(2); blk_pin = 1'b0; step(30);
        check("R9 retrigger start", b_start, lc + 3);
        check("R9 retrigger width", b_len, 4 + exp_w(3));
        check("R9 ocl retrigger width", o_len, 4 + exp_w(3));

        // R6: external bypass ignores bits 3:0
        foreach (ctrl_set[i]) ;
        for (int v = 0; v < 2; v++) begin
            ctrl = (v == 0) ? 8'h1F : 8'h10;
            step(10);
            nb = b_n;
            lc = cyc; hs_pin = 1'b1; step(5); hs_pin = 1'b0; step(20);
            check("R6 bypass count", b_n, nb + 1);
            check("R6 bypass start", b_start, lc + 2);
            check("R6 bypass width", b_len, 5);
        end

        // R7: force bits
        ctrl = 8'h20; step(1);
        check("R7 force bpcp", int'(bpcp_o), 1);
        check("R7 no force ocl", int'(ocl_o), 0);
        ctrl = 8'h40; step(1);
        check("R7 bpcp released", int'(bpcp_o), 0);
        check("R7 force ocl", int'(ocl_o), 1);
        ctrl = 8'hA0; step(1);
        check("R8 ocl follows forced bpcp", int'(ocl_o), 1);
        ctrl = 8'h04; step(5);
        check("R7 both released", int'(bpcp_o | ocl_o), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    int ctrl_set [1];

endmodule